// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block performs the configuration step of a scalable vector unit. On a strobe it takes a requested element count, an element-width code, a length-multiplier code and the tail and mask policy bits. It also takes two flags that say whether the source and destination scalar register indices are zero. In one cycle it computes the granted vector length, updates the vector type register and returns the granted length for write-back to the destination register.

The vector register width (`VLEN`) and the widest supported element (`ELEN`) are parameters. The hardware maximum length is `LMUL*VLEN/SEW`. It is computed as a power of two from the two codes, so no divider is needed. Fractional multipliers shrink the register slice the group occupies.

When the source index is zero, the request is replaced:
- If the destination index is non-zero, the unit grants the maximum length.
- If both indices are zero, the unit keeps the current length and changes only the type. The kept length is clamped if the new type cannot hold it.

Configurations that cannot be supported raise an ill flag and zero the length.

Top module: `vlcfg_top`

## Requirements
- R1: After synchronous reset the vector length reads 0, the ill flag reads 1, the type byte reads 0 and no destination write is signalled.
- R2: The type byte is {maskAgn[7], tailAgn[6], sew[5:3], lmul[2:0]}. The element-width codes are 000=8, 001=16, 010=32 and 011=64 bits. A request for 32-bit elements with multiplier code 001, tail agnostic and mask agnostic reads back as 0xD1 (209).
- R3: Multiplier codes 000 to 011 mean 1, 2, 4 and 8. With a non-zero source index, the new length is min(request, LMUL*VLEN/SEW).
- R4: Multiplier codes 101, 110 and 111 mean 1/8, 1/4 and 1/2, and they divide the maximum length accordingly.
- R5: A zero source index with a non-zero destination index grants the maximum length and ignores the requested count.
- R6: When both indices are zero, the new length is min(current length, new maximum). The type byte is updated and no destination write occurs.
- R7: The request is illegal if any of these holds:
  - the multiplier code is 100;
  - the element width exceeds `ELEN`;
  - VLEN*LMUL/ELEN is below 1.

  An illegal request sets the ill flag, forces the length to 0 and clears the type byte.
- R8: A strobe with a non-zero destination index drives the destination-write pulse high for exactly the next cycle, with the new length on the destination data. A strobe with a zero destination index leaves the pulse low.
- R9: Without a strobe, the length, type byte and ill flag hold, whatever the other inputs do.
- R10: Each strobe takes effect at the next clock edge, so strobes on back-to-back cycles each apply in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgValid | input | 1 | Configuration strobe |
| reqAvl | input | XLEN | Requested element count |
| reqSew | input | 3 | Element-width code |
| reqLmul | input | 3 | Length-multiplier code |
| reqTailAgn | input | 1 | Tail-agnostic policy bit |
| reqMaskAgn | input | 1 | Mask-agnostic policy bit |
| srcIsZero | input | 1 | Source register index is zero |
| dstIsZero | input | 1 | Destination register index is zero |
| curVl | output | $clog2(VLEN)+1 | Current vector length |
| curVtype | output | 8 | Current type byte |
| curVill | output | 1 | Ill configuration flag |
| dstWrite | output | 1 | Destination write pulse |
| dstData | output | XLEN | Granted length for the destination |

## Verification
The bench builds the unit with VLEN=128, ELEN=32 and XLEN=32. The narrow ELEN makes 64-bit elements illegal, and it makes the 1/8 multiplier illegal while 1/4 stays legal. This exercises both reject paths of the legality check next to legal fractional groups. With 128-bit registers the maximum spans 1 to 128 elements. The length therefore clamps from both sides, and the both-zero path meets a new maximum both below and above the current length.

// File: rtl/vlcfg_pkg.sv
package vlcfg_pkg;
  typedef struct packed {
    logic update;    // commit new vl / vtype
    logic useMax;    // grant the maximum length
    logic useCur;    // current vl is the request
    logic illegal;   // unsupported configuration
    logic writeDst;  // return the length to the destination
  } cfgStrobes_t;
endpackage

// File: rtl/vlcfg_ctrl.sv
module vlcfg_ctrl
  import vlcfg_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int ELEN = 64
) (
  input  logic        cfgValid,
  input  logic [2:0]  reqSew,
  input  logic [2:0]  reqLmul,
  input  logic        srcIsZero,
  input  logic        dstIsZero,
  output cfgStrobes_t strb
);
  localparam int LOG2VLEN = $clog2(VLEN);
  localparam int LOG2ELEN = $clog2(ELEN);
  localparam logic [2:0] ELEN_CODE = 3'(LOG2ELEN - 3);
  localparam logic [7:0] SPAN = 8'(LOG2VLEN - LOG2ELEN);

  logic [7:0] kExt;
  logic [7:0] elenRoom;   // log2(VLEN*LMUL/ELEN), two's complement

  always_comb begin
    kExt     = {{5{reqLmul[2]}}, reqLmul};
    elenRoom = SPAN + kExt;
    strb.update   = cfgValid;
    strb.useMax   = srcIsZero & ~dstIsZero;
    strb.useCur   = srcIsZero & dstIsZero;
    strb.illegal  = (reqLmul == 3'b100) | (reqSew > ELEN_CODE) | elenRoom[7];
    strb.writeDst = cfgValid & ~dstIsZero;
  end
endmodule

// File: rtl/vlcfg_dp.sv
module vlcfg_dp
  import vlcfg_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int XLEN = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  cfgStrobes_t             strb,
  input  logic [XLEN-1:0]         reqAvl,
  input  logic [2:0]              reqSew,
  input  logic [2:0]              reqLmul,
  input  logic                    reqTailAgn,
  input  logic                    reqMaskAgn,
  output logic [$clog2(VLEN):0]   curVl,
  output logic [7:0]              curVtype,
  output logic                    curVill,
  output logic                    dstWrite,
  output logic [XLEN-1:0]         dstData
);
  localparam int LOG2VLEN = $clog2(VLEN);
  localparam int VLW = LOG2VLEN + 1;
  localparam logic [VLW-1:0] ONE = VLW'(1);

  logic [7:0]      kExt;
  logic [7:0]      expo;      // log2(LMUL*VLEN/SEW)
  logic [VLW-1:0]  vlMax;
  logic [XLEN-1:0] avlSel;
  logic [XLEN-1:0] vlMaxX;
  logic [VLW-1:0]  nextVl;

  logic [VLW-1:0]  vlReg;
  logic [7:0]      vtypeReg;
  logic            villReg;

  always_comb begin
    kExt   = {{5{reqLmul[2]}}, reqLmul};
    expo   = 8'(LOG2VLEN) + kExt - 8'd3 - {5'b0, reqSew};
    vlMax  = expo[7] ? '0 : (ONE << expo);
    vlMaxX = XLEN'(vlMax);
    avlSel = strb.useCur ? XLEN'(vlReg) : reqAvl;
    if (strb.illegal)             nextVl = '0;
    else if (strb.useMax)         nextVl = vlMax;
    else if (avlSel < vlMaxX)     nextVl = avlSel[VLW-1:0];
    else                          nextVl = vlMax;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vlReg    <= '0;
      vtypeReg <= '0;
      villReg  <= 1'b1;
      dstWrite <= 1'b0;
      dstData  <= '0;
    end else begin
      dstWrite <= strb.writeDst;
      if (strb.writeDst) dstData <= XLEN'(nextVl);
      if (strb.update) begin
        vlReg    <= nextVl;
        villReg  <= strb.illegal;
        vtypeReg <= strb.illegal ? 8'h00 : {reqMaskAgn, reqTailAgn, reqSew, reqLmul};
      end
    end
  end

  assign curVl    = vlReg;
  assign curVtype = vtypeReg;
  assign curVill  = villReg;
endmodule

// File: rtl/vlcfg_top.sv
module vlcfg_top
  import vlcfg_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int ELEN = 64,
  parameter int XLEN = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfgValid,
  input  logic [XLEN-1:0]       reqAvl,
  input  logic [2:0]            reqSew,
  input  logic [2:0]            reqLmul,
  input  logic                  reqTailAgn,
  input  logic                  reqMaskAgn,
  input  logic                  srcIsZero,
  input  logic                  dstIsZero,
  output logic [$clog2(VLEN):0] curVl,
  output logic [7:0]            curVtype,
  output logic                  curVill,
  output logic                  dstWrite,
  output logic [XLEN-1:0]       dstData
);
  cfgStrobes_t strb;

  vlcfg_ctrl #(.VLEN(VLEN), .ELEN(ELEN)) u_ctrl (
    .cfgValid (cfgValid),
    .reqSew   (reqSew),
    .reqLmul  (reqLmul),
    .srcIsZero(srcIsZero),
    .dstIsZero(dstIsZero),
    .strb     (strb)
  );

  vlcfg_dp #(.VLEN(VLEN), .XLEN(XLEN)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .reqAvl    (reqAvl),
    .reqSew    (reqSew),
    .reqLmul   (reqLmul),
    .reqTailAgn(reqTailAgn),
    .reqMaskAgn(reqMaskAgn),
    .curVl     (curVl),
    .curVtype  (curVtype),
    .curVill   (curVill),
    .dstWrite  (dstWrite),
    .dstData   (dstData)
  );
endmodule

// File: rtl/vlcfg_chk.sv
module vlcfg_chk #(
  parameter int VLEN = 128,
  parameter int XLEN = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cfgValid,
  input logic                  srcIsZero,
  input logic                  dstIsZero,
  input logic [$clog2(VLEN):0] curVl,
  input logic [7:0]            curVtype,
  input logic                  curVill,
  input logic                  dstWrite,
  input logic [XLEN-1:0]       dstData
);
  // R7: an ill configuration holds a zero length
  a_r7_ill_zero_vl: assert property (@(posedge clk) disable iff (rst)
    curVill |-> (curVl == '0));
  // R7: an ill configuration holds a cleared type byte
  a_r7_ill_zero_vtype: assert property (@(posedge clk) disable iff (rst)
    curVill |-> (curVtype == 8'h00));
  // R3: length never exceeds the widest possible group
  a_r3_vl_bound: assert property (@(posedge clk) disable iff (rst)
    curVl <= ($clog2(VLEN)+1)'(VLEN));
  // R9: no strobe, no change
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !cfgValid |=> ($stable(curVl) && $stable(curVtype) && $stable(curVill)));
  // R6: keeping the current length never grows it
  a_r6_no_grow: assert property (@(posedge clk) disable iff (rst)
    (cfgValid && srcIsZero && dstIsZero) |=> (curVl <= $past(curVl)));
  // R8: a write pulse follows a strobe with a non-zero destination
  a_r8_dst_cause: assert property (@(posedge clk) disable iff (rst)
    dstWrite |-> ($past(cfgValid) && !$past(dstIsZero)));
  // R8: written data equals the granted length
  a_r8_dst_data: assert property (@(posedge clk) disable iff (rst)
    dstWrite |-> (dstData == XLEN'(curVl)));
endmodule

bind vlcfg_top vlcfg_chk #(.VLEN(VLEN), .XLEN(XLEN)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfgValid (cfgValid),
  .srcIsZero(srcIsZero),
  .dstIsZero(dstIsZero),
  .curVl    (curVl),
  .curVtype (curVtype),
  .curVill  (curVill),
  .dstWrite (dstWrite),
  .dstData  (dstData)
);

// File: tb/tb_vlcfg_top.sv
module tb_vlcfg_top;
  localparam int CLK_PERIOD = 10;
  localparam int VLEN = 128;
  localparam int ELEN = 32;
  localparam int XLEN = 32;
  localparam int VLW  = $clog2(VLEN) + 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cfgValid = 1'b0;
  logic [XLEN-1:0] reqAvl = '0;
  logic [2:0]      reqSew = '0;
  logic [2:0]      reqLmul = '0;
  logic            reqTailAgn = 1'b0;
  logic            reqMaskAgn = 1'b0;
  logic            srcIsZero = 1'b0;
  logic            dstIsZero = 1'b0;
  logic [VLW-1:0]  curVl;
  logic [7:0]      curVtype;
  logic            curVill;
  logic            dstWrite;
  logic [XLEN-1:0] dstData;

  vlcfg_top #(.VLEN(VLEN), .ELEN(ELEN), .XLEN(XLEN)) dut (
    .clk(clk), .rst(rst), .cfgValid(cfgValid), .reqAvl(reqAvl),
    .reqSew(reqSew), .reqLmul(reqLmul), .reqTailAgn(reqTailAgn),
    .reqMaskAgn(reqMaskAgn), .srcIsZero(srcIsZero), .dstIsZero(dstIsZero),
    .curVl(curVl), .curVtype(curVtype), .curVill(curVill),
    .dstWrite(dstWrite), .dstData(dstData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int    vl;
    int    vtype;
    int    vill;
    int    wr;
    string tag;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad = 0;
  int   mVl = 0;
  int   mVtype = 0;
  int   mVill = 1;
  bit   done = 0;

  task automatic check(input string tag, input string what, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // drive one cycle and push the expected result for the next edge
  task automatic drive(input bit v, input int avl, input int sew, input int lmul,
                       input bit ta, input bit ma, input bit s0, input bit d0,
                       input string tag);
    exp_t e;
    int sb, vmax, req, grp;
    bit ill;
    @(negedge clk);
    cfgValid = v; reqAvl = XLEN'(avl); reqSew = 3'(sew); reqLmul = 3'(lmul);
    reqTailAgn = ta; reqMaskAgn = ma; srcIsZero = s0; dstIsZero = d0;
    if (v) begin
      sb  = (sew <= 3) ? (8 << sew) : 4096;
      grp = (lmul < 4) ? (VLEN << lmul) : (VLEN >> (8 - lmul));
      ill = (lmul == 4) || (sb > ELEN) || (lmul >= 5 && grp < ELEN);
      if (ill) begin
        mVl = 0; mVtype = 0; mVill = 1;
      end else begin
        vmax = grp / sb;
        if (s0 && !d0)      req = vmax;
        else if (s0 && d0)  req = mVl;
        else                req = avl;
        mVl = (req < vmax) ? req : vmax;
        mVtype = (int'(ma) << 7) | (int'(ta) << 6) | (sew << 3) | lmul;
        mVill = 0;
      end
      e.wr = d0 ? 0 : 1;
    end else begin
      e.wr = 0;
    end
    e.vl = mVl; e.vtype = mVtype; e.vill = mVill; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares one quarter period after each edge
  always @(posedge clk) begin
    if (!rst) begin
      #(CLK_PERIOD/4);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, "vl", int'(curVl), e.vl);
        check(e.tag, "vtype", int'(curVtype), e.vtype);
        check(e.tag, "vill", int'(curVill), e.vill);
        check(e.tag, "dstWrite", int'(dstWrite), e.wr);
        if (e.wr == 1) check(e.tag, "dstData", int'(dstData), e.vl);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "vl", int'(curVl), 0);
    check("R1", "vill", int'(curVill), 1);
    check("R1", "vtype", int'(curVtype), 0);
    check("R1", "dstWrite", int'(dstWrite), 0);
    rst = 1'b0;
    // R2 / R3: e32, LMUL=2, ta, ma -> 0xD1, vlmax 8
    drive(1, 5, 2, 1, 1, 1, 0, 0, "R2");
    drive(1, 100, 0, 0, 0, 0, 0, 0, "R3");     // e8 m1: 16
    drive(1, 100, 0, 3, 1, 0, 0, 0, "R3");     // e8 m8: 100
    drive(1, 0, 1, 0, 0, 1, 0, 0, "R3");       // zero request
    // R4: fractional groups
    drive(1, 50, 1, 7, 0, 0, 0, 0, "R4");      // e16 mf2: 4
    drive(1, 3, 0, 6, 1, 1, 0, 0, "R4");       // e8 mf4: 3
    drive(1, 9, 2, 6, 0, 0, 0, 0, "R4");       // e32 mf4: 1
    // R5: maximum grant ignores request
    drive(1, 2, 1, 2, 1, 0, 1, 0, "R5");       // e16 m4: 32
    // R6: keep current, clamp down then no growth
    drive(1, 77, 2, 2, 1, 1, 1, 1, "R6");      // e32 m4: 16
    drive(1, 77, 1, 3, 0, 0, 1, 1, "R6");      // e16 m8: stays 16
    drive(1, 1, 2, 0, 0, 1, 1, 1, "R6");       // e32 m1: 4
    // R9: idle cycles with noisy inputs
    drive(0, 999, 0, 3, 1, 1, 0, 0, "R9");
    drive(0, 1, 4, 4, 0, 0, 1, 0, "R9");
    // R7: illegal forms
    drive(1, 10, 0, 4, 1, 1, 0, 0, "R7");      // reserved multiplier
    drive(1, 10, 1, 0, 0, 0, 0, 0, "R7");      // recover: 8
    drive(1, 10, 3, 0, 0, 0, 0, 0, "R7");      // e64 > ELEN
    drive(1, 10, 2, 5, 0, 0, 0, 0, "R7");      // mf8 too small at ELEN
    drive(1, 10, 4, 1, 0, 0, 1, 1, "R7");      // width code 100
    // R8: zero destination, no write
    drive(1, 6, 0, 1, 0, 0, 0, 1, "R8");       // e8 m2: 6
    drive(1, 40, 0, 1, 0, 0, 0, 0, "R8");      // 32, written
    // R10: back-to-back strobes
    drive(1, 7, 2, 0, 1, 0, 0, 0, "R10");
    drive(1, 3, 0, 0, 0, 1, 0, 0, "R10");
    drive(1, 200, 0, 3, 1, 1, 0, 0, "R10");
    drive(0, 0, 0, 0, 0, 0, 0, 0, "R9");
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule